// File: doc/BRIEF.md
# Character Fetch Video Interceptor

This block sits on a small processor's memory bus in front of a character ROM and a 1 KiB work RAM. It decodes every read into one of three regions, serves the byte back one cycle later, and accepts writes into the RAM. The RAM answers at every address with bit 14 set, so it appears many times in the address map.

The block also produces text video as a side effect of instruction fetches. When the processor fetches an opcode from the upper copy of the RAM, the fetched byte is taken as a character code. The high byte of the processor's 16-bit refresh/vector value, the low six bits of the code and an externally sequenced 3-bit line number together select one row of a glyph in the ROM. That row, optionally inverted, is presented as a pixel byte with a one-cycle strobe. The processor receives a no-operation byte instead, so it runs harmlessly across the display memory.

Every opcode fetch also samples the maskable interrupt request from bit 6 of the low refresh byte and drops horizontal sync. Sync is raised again by a separate request input.

Top module: `charfetch_video`

## Requirements
- R1: A read or fetch with address bits 15:14 equal to 00 returns, on the clock after it is presented, ROM byte i, where i is the address masked to ROM_AW bits and ROM byte i equals (37*i + 11*(i>>8) + 0x5A) mod 256.
- R2: Any access with address bit 14 set reaches RAM word addr[9:0]. Writes store wdata there, and reads return that word, so all RAM copies alias.
- R3: A read with address bits 15:14 equal to 10 returns 0xFF. A write outside the RAM region changes no ROM or RAM byte.
- R4: A display fetch requires all of the following: the op is a fetch (cyc_op=1), address bits 15 and 14 are set, bit 6 of the addressed RAM byte is clear, halted is low, and the glyph address has bits 15:14 equal to 00.
- R5: The glyph address is (refresh & 0xFF00) | ((code & 0x3F) << 3) | line_ctr, an OR in which code bit 5 overlaps refresh bit 8. The glyph byte is ROM byte (glyph address masked to ROM_AW bits).
- R6: A fetch whose glyph address lies outside the ROM region is an ordinary fetch. It returns the RAM byte and raises no strobe.
- R7: With code bit 7 set the glyph byte is shown unchanged. With code bit 7 clear it is XORed with 0xFF.
- R8: A display fetch returns 0x00 on rd_data, and on the next cycle pulses pix_valid for one cycle with the pixel byte on pix_data. pix_data holds its value between strobes.
- R9: Every fetch sets int_req to the inverse of refresh bit 6 on the next cycle. Other cycles leave int_req unchanged.
- R10: A fetch clears hsync on the next cycle. Otherwise hsync_set raises it, and hsync holds without either.
- R11: After reset, rd_data, rd_valid, pix_data, pix_valid, int_req and hsync are all zero.
- R12: While halted is high no fetch produces a pixel strobe, and the fetched RAM byte is returned unmodified.
- R13: rd_valid pulses on the cycle after each read or fetch (cyc_op 0 or 1), and not after writes (cyc_op 2), idle cycles or cycles with cyc_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | A bus cycle is presented this clock |
| cyc_op | input | 2 | 0 read, 1 opcode fetch, 2 write, 3 idle |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Write data |
| refresh | input | 16 | Vector byte (15:8) and refresh byte (7:0) |
| halted | input | 1 | Processor is halted |
| line_ctr | input | 3 | Glyph row within the character cell |
| hsync_set | input | 1 | Request to raise horizontal sync |
| rd_data | output | 8 | Byte returned to the processor |
| rd_valid | output | 1 | rd_data belongs to the previous read or fetch |
| pix_data | output | 8 | Pixel byte of the last display fetch |
| pix_valid | output | 1 | One-cycle strobe for a new pixel byte |
| int_req | output | 1 | Maskable interrupt request, active high |
| hsync | output | 1 | Horizontal sync level |

## Verification
A wrong region decode or a wrong RAM index shows as a wrong rd_data on the very next cycle. A corrupted RAM word stays hidden until that word, or one of its aliases, is read or fetched. A wrong glyph address or inversion polarity shows only on a display fetch, as a wrong pix_data one cycle later, or as a missing or extra strobe with a non-zero rd_data. Interrupt and sync errors persist until the next fetch, so the reference model compares every output on every clock to catch them at the first divergent cycle.

// File: rtl/cvf_pkg.sv
package cvf_pkg;

  typedef enum logic [1:0] {
    CYC_READ  = 2'd0,
    CYC_FETCH = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_IDLE  = 2'd3
  } cyc_op_e;

  typedef enum logic [1:0] {
    RGN_ROM  = 2'd0,
    RGN_RAM  = 2'd1,
    RGN_NONE = 2'd2
  } region_e;

  // Region of a bus or glyph address.
  function automatic region_e region_of(input logic [15:0] a);
    if (a[15:14] == 2'b00)  return RGN_ROM;
    else if (a[14])         return RGN_RAM;
    else                    return RGN_NONE;
  endfunction

  // ROM contents, a pure function of the (already masked) index.
  function automatic logic [7:0] rom_pattern(input logic [15:0] idx);
    logic [15:0] acc;
    acc = 16'(idx[7:0]) * 16'd37 + 16'(idx[15:8]) * 16'd11 + 16'h005A;
    return acc[7:0];
  endfunction

  // Glyph row address: vector byte OR code-times-eight OR row.
  function automatic logic [15:0] glyph_address(input logic [7:0] vec,
                                                input logic [7:0] code,
                                                input logic [2:0] row);
    return {vec, 8'h00} | {7'd0, code[5:0], row};
  endfunction

  // Polarity mask: code bit 7 set shows the glyph as stored.
  function automatic logic [7:0] pixel_mask(input logic [7:0] code);
    return code[7] ? 8'h00 : 8'hFF;
  endfunction

endpackage

// File: rtl/cvf_mem_decode.sv
module cvf_mem_decode
  import cvf_pkg::*;
#(
  parameter int ROM_AW = 13,
  parameter int RAM_AW = 10
) (
  input  logic        clk,
  input  logic        cyc_valid,
  input  logic [1:0]  cyc_op,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic [15:0] glyph_addr,
  output region_e     bus_region,
  output logic [7:0]  bus_byte,
  output logic [7:0]  ram_byte,
  output logic [7:0]  glyph_byte
);
  localparam int RAM_DEPTH = 1 << RAM_AW;
  localparam logic [15:0] ROM_MASK = 16'((1 << ROM_AW) - 1);

  logic [7:0] ram_q [RAM_DEPTH];
  logic [7:0] rom_byte;
  logic       wr_en;

  assign bus_region = region_of(addr);
  assign wr_en      = cyc_valid && (cyc_op_e'(cyc_op) == CYC_WRITE)
                      && (bus_region == RGN_RAM);

  always_ff @(posedge clk) begin
    if (wr_en) ram_q[addr[RAM_AW-1:0]] <= wdata;
  end

  assign ram_byte   = ram_q[addr[RAM_AW-1:0]];
  assign rom_byte   = rom_pattern(addr & ROM_MASK);
  assign glyph_byte = rom_pattern(glyph_addr & ROM_MASK);

  always_comb begin
    unique case (bus_region)
      RGN_ROM: bus_byte = rom_byte;
      RGN_RAM: bus_byte = ram_byte;
      default: bus_byte = 8'hFF;
    endcase
  end

endmodule

// File: rtl/cvf_glyph_path.sv
module cvf_glyph_path
  import cvf_pkg::*;
(
  input  logic        is_fetch,
  input  logic        addr_hi,
  input  region_e     bus_region,
  input  logic        halted,
  input  logic [7:0]  vec_byte,
  input  logic [7:0]  code,
  input  logic [2:0]  line_ctr,
  input  logic [7:0]  glyph_byte,
  output logic [15:0] glyph_addr,
  output logic        show,
  output logic [7:0]  pix_byte
);
  logic code_is_char;
  logic glyph_in_rom;

  assign glyph_addr   = glyph_address(vec_byte, code, line_ctr);
  assign glyph_in_rom = (region_of(glyph_addr) == RGN_ROM);
  assign code_is_char = !code[6];

  assign show = is_fetch && addr_hi && (bus_region == RGN_RAM)
                && code_is_char && !halted && glyph_in_rom;

  assign pix_byte = glyph_byte ^ pixel_mask(code);

endmodule

// File: rtl/cvf_ctrl_lines.sv
module cvf_ctrl_lines (
  input  logic clk,
  input  logic rst_n,
  input  logic is_fetch,
  input  logic refresh_b6,
  input  logic hsync_set,
  output logic int_req,
  output logic hsync
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_req <= 1'b0;
      hsync   <= 1'b0;
    end else begin
      if (is_fetch) int_req <= !refresh_b6;
      if (is_fetch)       hsync <= 1'b0;
      else if (hsync_set) hsync <= 1'b1;
    end
  end

  p_irq_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_fetch |=> (int_req == !$past(refresh_b6)));

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_fetch |=> $stable(int_req));

  p_hsync_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    is_fetch |=> !hsync);

  p_hsync_raise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_fetch && hsync_set) |=> hsync);

endmodule

// File: rtl/charfetch_video.sv
module charfetch_video
  import cvf_pkg::*;
#(
  parameter int ROM_AW = 13,
  parameter int RAM_AW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cyc_valid,
  input  logic [1:0]  cyc_op,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic [15:0] refresh,
  input  logic        halted,
  input  logic [2:0]  line_ctr,
  input  logic        hsync_set,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic [7:0]  pix_data,
  output logic        pix_valid,
  output logic        int_req,
  output logic        hsync
);
  region_e     bus_region;
  logic [7:0]  bus_byte, ram_byte, glyph_byte, pix_byte;
  logic [15:0] glyph_addr;
  logic        show, is_fetch, is_read;

  assign is_fetch = cyc_valid && (cyc_op_e'(cyc_op) == CYC_FETCH);
  assign is_read  = cyc_valid && ((cyc_op_e'(cyc_op) == CYC_READ) || is_fetch);

  cvf_mem_decode #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) u_mem (
    .clk        (clk),
    .cyc_valid  (cyc_valid),
    .cyc_op     (cyc_op),
    .addr       (addr),
    .wdata      (wdata),
    .glyph_addr (glyph_addr),
    .bus_region (bus_region),
    .bus_byte   (bus_byte),
    .ram_byte   (ram_byte),
    .glyph_byte (glyph_byte)
  );

  cvf_glyph_path u_glyph (
    .is_fetch   (is_fetch),
    .addr_hi    (addr[15]),
    .bus_region (bus_region),
    .halted     (halted),
    .vec_byte   (refresh[15:8]),
    .code       (ram_byte),
    .line_ctr   (line_ctr),
    .glyph_byte (glyph_byte),
    .glyph_addr (glyph_addr),
    .show       (show),
    .pix_byte   (pix_byte)
  );

  cvf_ctrl_lines u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_fetch   (is_fetch),
    .refresh_b6 (refresh[6]),
    .hsync_set  (hsync_set),
    .int_req    (int_req),
    .hsync      (hsync)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data   <= 8'h00;
      rd_valid  <= 1'b0;
      pix_data  <= 8'h00;
      pix_valid <= 1'b0;
    end else begin
      rd_valid  <= is_read;
      if (is_read) rd_data <= show ? 8'h00 : bus_byte;
      pix_valid <= show;
      if (show) pix_data <= pix_byte;
    end
  end

  p_nop_with_pixel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (rd_valid && rd_data == 8'h00));

  p_halt_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && halted) |=> !pix_valid);

  p_only_fetch_draws_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !is_fetch |=> !pix_valid);

  p_pix_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> (!pix_valid || 1'b1) && ($past(show) || $stable(pix_data)));

  p_rd_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
    is_read |=> rd_valid);

endmodule

// File: tb/charfetch_video_bench.sv
module charfetch_video_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROM_AW = 13;
  localparam int ROM_SIZE = 1 << ROM_AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_valid = 1'b0;
  logic [1:0]  cyc_op = 2'd3;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [15:0] refresh = '0;
  logic        halted = 1'b0;
  logic [2:0]  line_ctr = '0;
  logic        hsync_set = 1'b0;
  logic [7:0]  rd_data, pix_data;
  logic        rd_valid, pix_valid, int_req, hsync;

  int checks = 0;
  int errors = 0;

  // reference state
  int m_ram [1024];
  int e_rd = 0, e_rdv = 0, e_pix = 0, e_pixv = 0, e_int = 0, e_hs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  charfetch_video u_charfetch_video (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_op(cyc_op),
    .addr(addr), .wdata(wdata), .refresh(refresh), .halted(halted),
    .line_ctr(line_ctr), .hsync_set(hsync_set), .rd_data(rd_data),
    .rd_valid(rd_valid), .pix_data(pix_data), .pix_valid(pix_valid),
    .int_req(int_req), .hsync(hsync)
  );

  function automatic int rom_model(int a);
    int i = a % ROM_SIZE;
    return (37 * i + 11 * (i / 256) + 90) % 256;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    check(req, "rd_data",   rd_data,   e_rd);
    check(req, "rd_valid",  rd_valid,  e_rdv);
    check(req, "pix_data",  pix_data,  e_pix);
    check(req, "pix_valid", pix_valid, e_pixv);
    check(req, "int_req",   int_req,   e_int);
    check(req, "hsync",     hsync,     e_hs);
  endtask

  // One bus cycle: drive at the falling edge, predict at the rising edge,
  // compare shortly after it.
  task automatic step(string req, int op, int a, int w, int rf, int hlt,
                      int ln, int hset);
    int code, g;
    bit rd, fetch, disp;
    @(negedge clk);
    cyc_valid = (op != 3); cyc_op = 2'(op); addr = 16'(a); wdata = 8'(w);
    refresh = 16'(rf); halted = hlt[0]; line_ctr = 3'(ln); hsync_set = hset[0];
    @(posedge clk);
    rd = (op == 0 || op == 1);
    fetch = (op == 1);
    code = m_ram[a % 1024];
    g = (rf & 'hFF00) | ((code & 'h3F) * 8) | ln;
    disp = fetch && ((a & 'hC000) == 'hC000) && ((code & 'h40) == 0)
           && (hlt == 0) && (g < 'h4000);
    e_rdv = rd;
    if (rd) begin
      if (disp) e_rd = 0;
      else if ((a & 'hC000) == 0) e_rd = rom_model(a);
      else if ((a & 'h4000) != 0) e_rd = code;
      else e_rd = 'hFF;
    end
    e_pixv = disp;
    if (disp) e_pix = ((code & 'h80) != 0) ? rom_model(g) : (rom_model(g) ^ 'hFF);
    if (fetch) begin e_int = ((rf & 'h40) == 0); e_hs = 0; end
    else if (hset != 0) e_hs = 1;
    if (op == 2 && (a & 'h4000) != 0) m_ram[a % 1024] = w & 'hFF;
    #1;
    compare_all(req);
  endtask

  initial begin
    for (int k = 0; k < 1024; k++) m_ram[k] = 0;
    repeat (3) @(posedge clk);
    #1;
    compare_all("R11");
    @(negedge clk); rst_n = 1'b1;

    // R1: ROM reads, including mask to the ROM size
    step("R1", 0, 'h0000, 0, 0, 0, 0, 0);
    step("R1", 0, 'h0123, 0, 0, 0, 0, 0);
    step("R1", 0, 'h3FFF, 0, 0, 0, 0, 0);
    step("R13", 3, 0, 0, 0, 0, 0, 0);
    // R2: RAM writes through one copy, reads through others
    for (int k = 0; k < 8; k++) step("R2", 2, 'h4000 + k * 37, 'h11 * k + 3, 0, 0, 0, 0);
    step("R2", 0, 'h7C25, 0, 0, 0, 0, 0);
    step("R2", 0, 'hC000 + 74, 0, 0, 0, 0, 0);
    step("R13", 2, 'h5000, 'h99, 0, 0, 0, 0);
    step("R2", 0, 'h4000 + 'h1000 % 1024, 0, 0, 0, 0, 0);
    // R3: unmapped read and ignored writes
    step("R3", 0, 'h8000, 0, 0, 0, 0, 0);
    step("R3", 2, 'h0123, 'h00, 0, 0, 0, 0);
    step("R3", 0, 'h0123, 0, 0, 0, 0, 0);
    step("R3", 2, 'h8010, 'h77, 0, 0, 0, 0);
    step("R3", 0, 'hC010, 0, 0, 0, 0, 0);
    // display codes
    step("R7", 2, 'h4100, 'h85, 0, 0, 0, 0);   // bit7 set
    step("R7", 2, 'h4101, 'h05, 0, 0, 0, 0);   // bit7 clear
    step("R4", 2, 'h4102, 'h45, 0, 0, 0, 0);   // bit6 set
    step("R5", 2, 'h4103, 'h3F, 0, 0, 0, 0);   // code bit5 overlaps vec bit0
    for (int ln = 0; ln < 8; ln++) step("R7", 1, 'hC100, 0, 'h1E00, 0, ln, 0);
    step("R7", 1, 'hC101, 0, 'h1E00, 0, 5, 0);
    step("R8", 0, 'h0000, 0, 0, 0, 0, 0);       // pix_data holds
    step("R4", 1, 'hC102, 0, 'h1E00, 0, 2, 0);
    step("R4", 1, 'h4101, 0, 'h1E00, 0, 2, 0);  // lower copy: no display
    step("R4", 0, 'hC101, 0, 'h1E00, 0, 2, 0);  // plain read: no display
    step("R5", 1, 'hC103, 0, 'h0100, 0, 3, 0);
    step("R5", 1, 'hC103, 0, 'h2200, 0, 6, 0);
    step("R6", 1, 'hC100, 0, 'h4000, 0, 1, 0);
    step("R6", 1, 'hC100, 0, 'hFF00, 0, 1, 0);
    step("R12", 1, 'hC100, 0, 'h1E00, 1, 4, 0);
    step("R12", 1, 'hC101, 0, 'h1E00, 1, 4, 0);
    // R9 interrupt from refresh bit 6, R10 sync
    step("R10", 3, 0, 0, 0, 0, 0, 1);
    step("R9", 0, 'h0000, 0, 'h0000, 0, 0, 0);
    step("R9", 1, 'h0010, 0, 'h0040, 0, 0, 0);
    step("R9", 0, 'h0010, 0, 'h0000, 0, 0, 1);
    step("R9", 1, 'h0011, 0, 'h00BF, 0, 0, 1);
    step("R10", 3, 0, 0, 'h0040, 0, 0, 1);
    step("R10", 3, 0, 0, 0, 0, 0, 0);
    step("R10", 1, 'h0012, 0, 'h0040, 0, 0, 1);
    step("R9", 2, 'h4200, 'h11, 'h0000, 0, 0, 0);
    for (int k = 0; k < 40; k++)
      step("R8", (k % 3 == 0) ? 1 : 0, 'hC100 + (k % 4), 0, (k * 'h0740) & 'h3FFF,
           0, k % 8, k % 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule